// File: doc/BRIEF.md
# Flash supervisory command sequencer

This block serves a supervisory call from a small CPU model or from an external programmer. The call presents a function code, two key bytes, the caller's stack pointer, a block or table identifier, an SRAM start offset and an SRAM page number. The block accepts the call only when the keys match. It then runs the requested operation byte by byte on a behavioural flash array that it holds itself. The operations are: program a 128-byte block from SRAM, clear a block, wipe the whole user area, or stream a table from a read-only table store.

Each user block carries a 2-bit protection mode that is set through a side port while the block is idle. A write or clear that hits a locked block is aborted. Results come back as three bytes: an accumulator value and two key locations. A wipe requested by internal code halts the CPU model and touches nothing. A plain read port exposes the whole array, including the hidden blocks above the user area, so that the contents can be observed.

Top module: `flash_sup_seq`

## Requirements
- R1: After reset, busy_o, done_o, halt_o, tbl_vld_o, acc_o, key1_o and key2_o are 0. Every user byte reads 00h. Every hidden byte at block b, offset i reads ((16*b+i) mod 256) XOR C3h.
- R2: A call is accepted only if key1_i is 3Ah and key2_i equals (sp_i+3) mod 256. Otherwise, one cycle after the call, done_o pulses with acc_o=FFh, key1_o=02h and key2_o=00h, busy_o stays low and nothing changes.
- R3: The function codes are 02h (program), 03h (clear block), 05h (wipe) and 06h (table read). Any other code is rejected exactly as in R2. So is a program or clear with blk_id_i of USER_BLK or more, and a table read with blk_id_i of NTBL or more.
- R4: Program writes byte i (0..127) of the block from SRAM address {page_i, (ptr_i+i) mod 256}. busy_o is high from the cycle after the call until done_o, which pulses 129 cycles after the call edge. On success acc_o=00h, key1_o=3Ah and key2_o echoes key2_i.
- R5: Clear block sets all 128 bytes of the target block to 00h, with the same timing and success result as R4.
- R6: Protection modes are 00b open, 01b read-locked (writes allowed), 10b external writes blocked and 11b all writes blocked. A blocked program or clear gives done_o one cycle after the call with acc_o=00h, key1_o=01h and key2_o=00h, and changes nothing.
- R7: A wipe with ext_i=1 takes USER_BLK*128 cycles. It sets every user byte to 00h, returns every protection mode to 00b and leaves the hidden blocks unchanged. The result is the same as in R4.
- R8: A valid wipe with ext_i=0 sets halt_o, which stays set. No done_o follows, the flash and the protection modes are unchanged, and later calls and protection updates are ignored.
- R9: Table read streams TBL_LEN bytes on tbl_vld_o/tbl_data_o on consecutive cycles, starting the cycle after the call. Byte k of table t is ((16*t+k) mod 256) XOR 5Ah. done_o comes with the last byte, with acc_o=REV_ID, key1_o=3Ah and key2_o echoing key2_i.
- R10: Calls and protection updates that arrive while busy_o is high are ignored.
- R11: done_o is a single-cycle pulse and is never high together with busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call strobe, one cycle |
| func_i | input | 8 | Function code |
| key1_i | input | 8 | Fixed key |
| key2_i | input | 8 | Stack-relative key |
| sp_i | input | 8 | Caller stack pointer |
| blk_id_i | input | 8 | Block number or table number |
| ptr_i | input | 8 | First SRAM offset for program |
| page_i | input | PW | SRAM page for program |
| ext_i | input | 1 | Call comes from external programmer |
| sram_addr_o | output | PW+8 | SRAM read address {page, offset} |
| sram_data_i | input | 8 | SRAM read data, same cycle |
| prot_set_i | input | 1 | Protection update strobe |
| prot_blk_i | input | 8 | Block to update |
| prot_mode_i | input | 2 | New protection mode |
| rd_addr_i | input | AW | Flash array read address |
| rd_data_o | output | 8 | Flash array read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| halt_o | output | 1 | CPU halted |
| acc_o | output | 8 | Returned accumulator |
| key1_o | output | 8 | Returned first key location |
| key2_o | output | 8 | Returned second key location |
| tbl_vld_o | output | 1 | Table byte valid |
| tbl_data_o | output | 8 | Table byte |

## Verification
The bench builds the block with its defaults: 8 user blocks, 2 hidden blocks, 128-byte blocks, 4 SRAM pages, and 4 tables of 8 bytes. With 128 bytes and an 8-bit offset, start offsets near FFh wrap inside the page, and the random mix reaches all four pages. Block identifiers up to 11 hit the hidden blocks and must be rejected. A full wipe takes only 1024 cycles, so several random wipes fit in one run next to locked blocks, each followed by a compare of the complete array, hidden blocks included.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_WR, OP_ER, OP_EA, OP_TR} op_e;

  localparam logic [7:0] FN_WR = 8'h02;
  localparam logic [7:0] FN_ER = 8'h03;
  localparam logic [7:0] FN_EA = 8'h05;
  localparam logic [7:0] FN_TR = 8'h06;

  localparam logic [7:0] KEY_FIXED  = 8'h3A;
  localparam logic [7:0] KEY_SP_OFS = 8'h03;
  localparam logic [7:0] ST_PROT    = 8'h01;
  localparam logic [7:0] ST_REJ     = 8'h02;
  localparam logic [7:0] ACC_REJ    = 8'hFF;

  localparam logic [1:0] PM_OPEN    = 2'b00;
  localparam logic [1:0] PM_EXTLOCK = 2'b10;
  localparam logic [1:0] PM_FULL    = 2'b11;

  function automatic logic [7:0] tbl_byte(input logic [7:0] t, input logic [7:0] k);
    return ((t << 4) + k) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] hid_byte(input int b, input int i);
    return 8'((b * 16 + i) & 255) ^ 8'hC3;
  endfunction
endpackage

// File: rtl/fss_keychk.sv
module fss_keychk
  import fss_pkg::*;
#(
  parameter int USER_BLK = 8,
  parameter int NTBL     = 4
) (
  input  logic [7:0] func_i,
  input  logic [7:0] key1_i,
  input  logic [7:0] key2_i,
  input  logic [7:0] sp_i,
  input  logic [7:0] id_i,
  output op_e        op_o,
  output logic       key_ok_o,
  output logic       arg_ok_o
);
  always_comb begin
    case (func_i)
      FN_WR:   op_o = OP_WR;
      FN_ER:   op_o = OP_ER;
      FN_EA:   op_o = OP_EA;
      FN_TR:   op_o = OP_TR;
      default: op_o = OP_NONE;
    endcase
  end

  assign key_ok_o = (key1_i == KEY_FIXED) && (key2_i == 8'(sp_i + KEY_SP_OFS));

  always_comb begin
    case (op_o)
      OP_WR, OP_ER: arg_ok_o = 32'(id_i) < USER_BLK;
      OP_TR:        arg_ok_o = 32'(id_i) < NTBL;
      OP_EA:        arg_ok_o = 1'b1;
      default:      arg_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fss_array.sv
module fss_array
  import fss_pkg::*;
#(
  parameter int USER_BLK  = 8,
  parameter int HID_BLK   = 2,
  parameter int BLK_BYTES = 128,
  localparam int DEPTH    = (USER_BLK + HID_BLK) * BLK_BYTES,
  localparam int AW       = $clog2(DEPTH),
  localparam int UW       = $clog2(USER_BLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          pset_i,
  input  logic [UW-1:0] pset_idx_i,
  input  logic [1:0]    pset_mode_i,
  input  logic          pclr_i,
  input  logic [UW-1:0] pq_idx_i,
  output logic [1:0]    pq_mode_o,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int USER_BYTES = USER_BLK * BLK_BYTES;

  logic [7:0] mem_q [DEPTH];
  logic [1:0] prot_q [USER_BLK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++)
        mem_q[a] <= (a < USER_BYTES) ? 8'h00 : hid_byte(a / BLK_BYTES, a % BLK_BYTES);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < USER_BLK; b++) prot_q[b] <= PM_OPEN;
    end else if (pclr_i) begin
      for (int b = 0; b < USER_BLK; b++) prot_q[b] <= PM_OPEN;
    end else if (pset_i) begin
      prot_q[pset_idx_i] <= pset_mode_i;
    end
  end

  assign pq_mode_o = prot_q[pq_idx_i];
  assign rdata_o   = (32'(raddr_i) < DEPTH) ? mem_q[raddr_i] : 8'h00;

  // hidden region is never a write target
  a_r7_user_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < USER_BYTES));
endmodule

// File: rtl/flash_sup_seq.sv
module flash_sup_seq
  import fss_pkg::*;
#(
  parameter int          USER_BLK  = 8,
  parameter int          HID_BLK   = 2,
  parameter int          BLK_BYTES = 128,
  parameter int          PAGES     = 4,
  parameter int          NTBL      = 4,
  parameter int          TBL_LEN   = 8,
  parameter logic [7:0]  REV_ID    = 8'h21,
  localparam int         PW        = $clog2(PAGES),
  localparam int         AW        = $clog2((USER_BLK + HID_BLK) * BLK_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [7:0]    func_i,
  input  logic [7:0]    key1_i,
  input  logic [7:0]    key2_i,
  input  logic [7:0]    sp_i,
  input  logic [7:0]    blk_id_i,
  input  logic [7:0]    ptr_i,
  input  logic [PW-1:0] page_i,
  input  logic          ext_i,
  output logic [PW+7:0] sram_addr_o,
  input  logic [7:0]    sram_data_i,
  input  logic          prot_set_i,
  input  logic [7:0]    prot_blk_i,
  input  logic [1:0]    prot_mode_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          halt_o,
  output logic [7:0]    acc_o,
  output logic [7:0]    key1_o,
  output logic [7:0]    key2_o,
  output logic          tbl_vld_o,
  output logic [7:0]    tbl_data_o
);
  localparam int UW = $clog2(USER_BLK);
  localparam int CW = $clog2(USER_BLK * BLK_BYTES);

  op_e           op_d, op_q;
  logic          key_ok, arg_ok;
  logic          busy_q, done_q, halt_q, ext_q, tv_q;
  logic [7:0]    acc_q, k1_q, k2_q, key2_q, blk_q, ptr_q, td_q;
  logic [PW-1:0] page_q;
  logic [CW-1:0] cnt_q, last_q, last_d;
  logic [7:0]    pq_blk;
  logic [1:0]    pq_raw, pq_mode;
  logic          blocked, we, pset, pclr;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;

  fss_keychk #(.USER_BLK(USER_BLK), .NTBL(NTBL)) u_keychk (
    .func_i(func_i), .key1_i(key1_i), .key2_i(key2_i), .sp_i(sp_i), .id_i(blk_id_i),
    .op_o(op_d), .key_ok_o(key_ok), .arg_ok_o(arg_ok)
  );

  // protection lookup: the latched block while running, the requested block while idle
  assign pq_blk  = busy_q ? blk_q : blk_id_i;
  assign pq_mode = (32'(pq_blk) < USER_BLK) ? pq_raw : PM_OPEN;
  assign blocked = (pq_mode == PM_FULL) || ((busy_q ? ext_q : ext_i) && pq_mode == PM_EXTLOCK);

  assign we    = busy_q && (op_q == OP_WR || op_q == OP_ER || op_q == OP_EA);
  assign waddr = (op_q == OP_EA) ? AW'(cnt_q) : AW'(blk_q) * AW'(BLK_BYTES) + AW'(cnt_q);
  assign wdata = (op_q == OP_WR) ? sram_data_i : 8'h00;
  assign pset  = prot_set_i && !busy_q && !halt_q && (32'(prot_blk_i) < USER_BLK);
  assign pclr  = busy_q && op_q == OP_EA && cnt_q == last_q;
  assign sram_addr_o = {page_q, 8'(ptr_q + 8'(cnt_q))};

  fss_array #(.USER_BLK(USER_BLK), .HID_BLK(HID_BLK), .BLK_BYTES(BLK_BYTES)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .pset_i(pset), .pset_idx_i(prot_blk_i[UW-1:0]), .pset_mode_i(prot_mode_i), .pclr_i(pclr),
    .pq_idx_i(pq_blk[UW-1:0]), .pq_mode_o(pq_raw),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  always_comb begin
    case (op_d)
      OP_EA:   last_d = CW'(USER_BLK * BLK_BYTES - 1);
      OP_TR:   last_d = CW'(TBL_LEN - 1);
      default: last_d = CW'(BLK_BYTES - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; halt_q <= 1'b0; tv_q <= 1'b0;
      acc_q <= '0; k1_q <= '0; k2_q <= '0; td_q <= '0;
      op_q <= OP_NONE; blk_q <= '0; ptr_q <= '0; page_q <= '0; ext_q <= 1'b0;
      key2_q <= '0; cnt_q <= '0; last_q <= '0;
    end else begin
      done_q <= 1'b0;
      tv_q   <= 1'b0;
      if (!busy_q) begin
        if (call_i && !halt_q) begin
          if (!key_ok || !arg_ok) begin
            done_q <= 1'b1; acc_q <= ACC_REJ; k1_q <= ST_REJ; k2_q <= 8'h00;
          end else if (op_d == OP_EA && !ext_i) begin
            halt_q <= 1'b1;
          end else if ((op_d == OP_WR || op_d == OP_ER) && blocked) begin
            done_q <= 1'b1; acc_q <= 8'h00; k1_q <= ST_PROT; k2_q <= 8'h00;
          end else begin
            busy_q <= 1'b1; op_q <= op_d; blk_q <= blk_id_i; ptr_q <= ptr_i;
            page_q <= page_i; ext_q <= ext_i; key2_q <= key2_i;
            cnt_q <= '0; last_q <= last_d;
          end
        end
      end else begin
        if (op_q == OP_TR) begin
          tv_q <= 1'b1;
          td_q <= tbl_byte(blk_q, 8'(cnt_q));
        end
        if (cnt_q == last_q) begin
          busy_q <= 1'b0; done_q <= 1'b1;
          acc_q  <= (op_q == OP_TR) ? REV_ID : 8'h00;
          k1_q   <= KEY_FIXED; k2_q <= key2_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;     assign done_o = done_q;   assign halt_o = halt_q;
  assign acc_o  = acc_q;      assign key1_o = k1_q;     assign key2_o = k2_q;
  assign tbl_vld_o = tv_q;    assign tbl_data_o = td_q;

  a_r2_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !busy_q && !halt_q && !key_ok) |=> (done_q && !busy_q && k1_q == ST_REJ));
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= last_q));
  a_r6_no_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && op_q != OP_EA) |-> !blocked);
  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> halt_q);
  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> (!we && !busy_q));
  a_r10_hold_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != last_q) |=> (busy_q && $stable(op_q) && $stable(blk_q)));
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: tb/sim_flash_sup_seq.sv
module sim_flash_sup_seq;
  localparam int UB = 8, HB = 2, BB = 128, PAGES = 4, NTBL = 4, TL = 8;
  localparam logic [7:0] REV = 8'h21;
  localparam int DEPTH = (UB + HB) * BB;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic call = 1'b0, ext = 1'b0, pset = 1'b0;
  logic [7:0] func = '0, k1 = '0, k2 = '0, sp = '0, bid = '0, ptr = '0, pblk = '0;
  logic [1:0] pmode = '0;
  logic [PW-1:0] page = '0;
  logic [PW+7:0] sram_addr;
  logic [7:0] sram_data, rd_data, acc, key1o, key2o, tdata;
  logic [AW-1:0] rd_addr = '0;
  logic busy, done, halt, tvld;

  logic [7:0] sram [PAGES*256];
  logic [7:0] mf [DEPTH];
  logic [1:0] mp [UB];
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign sram_data = sram[sram_addr];

  flash_sup_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .func_i(func), .key1_i(k1), .key2_i(k2),
    .sp_i(sp), .blk_id_i(bid), .ptr_i(ptr), .page_i(page), .ext_i(ext),
    .sram_addr_o(sram_addr), .sram_data_i(sram_data),
    .prot_set_i(pset), .prot_blk_i(pblk), .prot_mode_i(pmode),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .halt_o(halt), .acc_o(acc), .key1_o(key1o), .key2_o(key2o),
    .tbl_vld_o(tvld), .tbl_data_o(tdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_hid(input int b, input int i);
    return 8'((b * 16 + i) % 256) ^ 8'hC3;
  endfunction

  function automatic logic [7:0] exp_tbl(input int t, input int k);
    return 8'((t * 16 + k) % 256) ^ 8'h5A;
  endfunction

  task automatic check_array(input string req);
    int bad = 0;
    logic [7:0] fa = 0, fe = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== mf[a]) begin
        if (bad == 0) begin fa = rd_data; fe = mf[a]; end
        bad++;
      end
    end
    chk(req, "array contents", {24'd0, fa}, {24'd0, fe});
    if (bad != 0) $display("  %0d mismatching bytes", bad);
  endtask

  task automatic set_prot(input int b, input logic [1:0] m);
    @(negedge clk);
    pset = 1'b1; pblk = 8'(b); pmode = m;
    @(negedge clk);
    pset = 1'b0;
    if (b < UB) mp[b] = m;
  endtask

  // inject > 0: drive a competing call and protection update at that cycle
  task automatic run_call(input string req, input logic [7:0] f, input logic [7:0] a1,
                          input logic [7:0] a2, input logic [7:0] s, input logic [7:0] b,
                          input logic [7:0] p, input int pg, input logic e, input int inject);
    bit keyok = (a1 == 8'h3A) && (a2 == 8'(s + 8'd3));
    bit fok   = (f == 8'h02) || (f == 8'h03) || (f == 8'h05) || (f == 8'h06);
    bit aok   = ((f == 8'h02 || f == 8'h03) && int'(b) < UB) || (f == 8'h05) ||
                (f == 8'h06 && int'(b) < NTBL);
    int kind, ecyc, cyc, nb, ng;
    logic [7:0] ea, e1, e2;
    logic [7:0] got [TL];
    if (!keyok || !fok || !aok) begin kind = 0; ecyc = 1; ea = 8'hFF; e1 = 8'h02; e2 = 8'h00; end
    else if ((f == 8'h02 || f == 8'h03) && (mp[b] == 2'b11 || (e && mp[b] == 2'b10))) begin
      kind = 1; ecyc = 1; ea = 8'h00; e1 = 8'h01; e2 = 8'h00;
    end else begin
      kind = 2; e1 = 8'h3A; e2 = a2; ea = (f == 8'h06) ? REV : 8'h00;
      ecyc = (f == 8'h05) ? UB * BB + 1 : (f == 8'h06) ? TL + 1 : BB + 1;
    end
    @(negedge clk);
    call = 1'b1; func = f; k1 = a1; k2 = a2; sp = s; bid = b; ptr = p; page = PW'(pg); ext = e;
    cyc = 0; nb = 0; ng = 0;
    do begin
      @(negedge clk);
      cyc++;
      call = (inject > 0 && cyc == inject);
      if (inject > 0 && cyc == inject) begin func = 8'h03; pset = 1'b1; pblk = b; pmode = 2'b11; end
      else pset = 1'b0;
      if (tvld && ng < TL) begin got[ng] = tdata; ng++; end
      if (!done && !busy) nb++;
    end while (!done && cyc < 3000);
    call = 1'b0; pset = 1'b0;
    chk(req, "cycles to done", cyc, ecyc);
    chk(req, "acc", {24'd0, acc}, {24'd0, ea});
    chk(req, "key1", {24'd0, key1o}, {24'd0, e1});
    chk(req, "key2", {24'd0, key2o}, {24'd0, e2});
    if (kind == 2) chk(req, "busy gaps", nb, 0);
    @(negedge clk);
    chk("R11", "done pulse width", {31'd0, done}, 0);
    if (inject > 0) begin
      for (int i = 0; i < BB + 20; i++) begin @(negedge clk); if (done) nb++; end
      chk("R10", "extra done after ignored call", nb, 0);
    end
    if (kind == 2 && f == 8'h06) begin
      chk("R9", "table byte count", ng, TL);
      for (int k = 0; k < TL; k++)
        chk("R9", "table byte", {24'd0, got[k]}, {24'd0, exp_tbl(b, k)});
    end
    if (kind == 2) begin
      if (f == 8'h02)
        for (int i = 0; i < BB; i++) mf[b * BB + i] = sram[pg * 256 + ((p + i) % 256)];
      else if (f == 8'h03)
        for (int i = 0; i < BB; i++) mf[b * BB + i] = 8'h00;
      else if (f == 8'h05) begin
        for (int a = 0; a < UB * BB; a++) mf[a] = 8'h00;
        for (int j = 0; j < UB; j++) mp[j] = 2'b00;
      end
    end
    check_array(req);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd8675309);
    for (int a = 0; a < PAGES * 256; a++) sram[a] = 8'($urandom);
    for (int a = 0; a < DEPTH; a++) mf[a] = (a < UB * BB) ? 8'h00 : exp_hid(a / BB, a % BB);
    for (int j = 0; j < UB; j++) mp[j] = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'd0, busy}, 0);
    chk("R1", "done", {31'd0, done}, 0);
    chk("R1", "halt", {31'd0, halt}, 0);
    chk("R1", "results", {acc, key1o, key2o, 7'd0, tvld}, 0);
    rst_n = 1'b1;
    check_array("R1");

    run_call("R4", 8'h02, 8'h3A, 8'h01, 8'hFE, 8'd3, 8'hF0, 2, 1'b0, 0);
    run_call("R4", 8'h02, 8'h3A, 8'h13, 8'h10, 8'd7, 8'h00, 1, 1'b1, 0);
    run_call("R5", 8'h03, 8'h3A, 8'h13, 8'h10, 8'd3, 8'h00, 0, 1'b0, 0);
    run_call("R9", 8'h06, 8'h3A, 8'h43, 8'h40, 8'd2, 8'h00, 0, 1'b0, 0);
    run_call("R3", 8'h06, 8'h3A, 8'h43, 8'h40, 8'd4, 8'h00, 0, 1'b0, 0);
    run_call("R3", 8'h04, 8'h3A, 8'h43, 8'h40, 8'd1, 8'h00, 0, 1'b0, 0);
    run_call("R3", 8'h02, 8'h3A, 8'h43, 8'h40, 8'd8, 8'h00, 0, 1'b1, 0);
    run_call("R2", 8'h02, 8'h3B, 8'h43, 8'h40, 8'd1, 8'h00, 0, 1'b0, 0);
    run_call("R2", 8'h02, 8'h3A, 8'h44, 8'h40, 8'd1, 8'h00, 0, 1'b0, 0);

    set_prot(4, 2'b11);
    run_call("R6", 8'h02, 8'h3A, 8'h03, 8'h00, 8'd4, 8'h20, 3, 1'b0, 0);
    set_prot(4, 2'b10);
    run_call("R6", 8'h02, 8'h3A, 8'h03, 8'h00, 8'd4, 8'h20, 3, 1'b0, 0);
    run_call("R6", 8'h03, 8'h3A, 8'h03, 8'h00, 8'd4, 8'h20, 3, 1'b1, 0);
    set_prot(4, 2'b01);
    run_call("R6", 8'h03, 8'h3A, 8'h03, 8'h00, 8'd4, 8'h20, 3, 1'b1, 0);

    // R10: competing erase call and lock request while a program runs
    run_call("R10", 8'h02, 8'h3A, 8'h08, 8'h05, 8'd1, 8'h80, 1, 1'b0, 6);
    run_call("R10", 8'h03, 8'h3A, 8'h08, 8'h05, 8'd1, 8'h00, 0, 1'b0, 0);

    set_prot(5, 2'b11);
    run_call("R4", 8'h02, 8'h3A, 8'h08, 8'h05, 8'd6, 8'hC1, 3, 1'b0, 0);
    run_call("R7", 8'h05, 8'h3A, 8'h08, 8'h05, 8'd0, 8'h00, 0, 1'b1, 0);
    run_call("R7", 8'h02, 8'h3A, 8'h08, 8'h05, 8'd5, 8'h77, 2, 1'b0, 0);

    for (int n = 0; n < 50; n++) begin
      logic [7:0] f, a1, a2, s;
      logic e;
      int sel = $urandom % 12;
      f = (sel < 4) ? 8'h02 : (sel < 7) ? 8'h03 : (sel < 9) ? 8'h06 : (sel == 9) ? 8'h05 : 8'($urandom);
      s = 8'($urandom); a1 = 8'h3A; a2 = 8'(s + 8'd3);
      if ($urandom % 6 == 0) begin
        if ($urandom % 2 == 0) a1 = 8'h3C; else a2 = 8'(s + 8'd9);
      end
      e = 1'($urandom);
      if (f == 8'h05) e = 1'b1;
      if ($urandom % 3 == 0) set_prot($urandom % UB, 2'($urandom));
      run_call("R4", f, a1, a2, s, 8'($urandom % 12), 8'($urandom), $urandom % PAGES, e, 0);
    end

    // R8: wipe from internal code halts and freezes everything
    set_prot(2, 2'b11);
    @(negedge clk);
    call = 1'b1; func = 8'h05; k1 = 8'h3A; sp = 8'h20; k2 = 8'h23; ext = 1'b0;
    @(negedge clk);
    call = 1'b0;
    chk("R8", "halt set", {31'd0, halt}, 1);
    begin
      int nd = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done || busy) nd++;
        call = (i == 5); func = 8'h03; bid = 8'd2; ext = 1'b1;
        pset = (i == 10); pblk = 8'd2; pmode = 2'b00;
      end
      call = 1'b0; pset = 1'b0;
      chk("R8", "activity while halted", nd, 0);
    end
    chk("R8", "halt held", {31'd0, halt}, 1);
    check_array("R8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule